// File: doc/BRIEF.md
# Mode-Steered Analog Boundary Cell Controller

This block is the digital control part of one boundary cell in a mixed-signal test chain. It holds a four-stage scan segment. Each stage has a shift flop and an update latch. The segment shifts serial test data, captures the cell's comparator result, and publishes a new switch code on an update strobe. A purely combinational decoder combines the published code with three global mode lines and drives thirteen switch enables. These cover the pin reference switches, the bus switches, a complementary group of internal bypass switches, a one-hot comparator reference selector and the core connection switch.

The third mode line lets the same two-bit reference code and the two bus bits steer a second group of switches. In the compare-level test mode, the pin reference switches are held open and their code picks the comparator reference level instead. In the internal test mode, the bus bits drive the core directly from the analog bus through bypass switches while the core connection switch opens. The analog switches and the comparator are outside this block. The block runs on one clock with shift, capture and update enables and a synchronous active-high reset.

Top module: `xbc_cell_ctl`

## Requirements
- R1: While `dr_clk_en` and `shift_sel` are both high, each clock moves data one stage along the path `scan_in` -> D -> C -> B1 -> B2. `scan_out` shows the B2 shift stage, so a bit shifted in appears on `scan_out` after four shift clocks.
- R2: The update latches, and therefore every switch output for fixed mode lines, change only on a clock where `upd_en` is high. Shift and capture clocks leave the outputs unchanged.
- R3: A clock with `dr_clk_en` high and `shift_sel` low loads `cmp_in` into the D shift stage. The C, B1 and B2 shift stages keep their values.
- R4: A clock with `rst` high clears all shift stages and update latches. With every latch at zero, all pin, bus, internal and compare-level switches are open, `cmp_sel_vth` is on, and `scan_out` is 0.
- R5: The reference code {C,D} means 11 = high level, 10 = low level, 01 = ground level and 00 = none. With mode lines (a,b,c) = (1,0,0), the code drives `sw_pin_vh`, `sw_pin_vl` or `sw_pin_vg`, and under any other mode these pin switches are open.
- R6: `sw_bus1` = B1 & a & ~c and `sw_int_bus1` = B1 & a & c. `sw_bus2` and `sw_int_bus2` are formed the same way from B2.
- R7: `sw_int_vg` = C & ~D & a & c.
- R8: With mode lines (1,0,1), all pin reference switches are open. Codes 11, 10 and 01 assert `cmp_sel_vh`, `cmp_sel_vl` and `cmp_sel_vg`, and code 00 asserts `cmp_sel_vth`. Under any other mode, only `cmp_sel_vth` is asserted.
- R9: Exactly one of `cmp_sel_vh`, `cmp_sel_vl`, `cmp_sel_vg` and `cmp_sel_vth` is high at all times, and `cmp_sel_vth` is high whenever mode line c is low.
- R10: `sw_core` is low only when all three mode lines are high, and high otherwise.
- R11: No bus switch of the normal group (`sw_bus1`, `sw_bus2`) is on together with any switch of the internal group (`sw_int_bus1`, `sw_int_bus2`, `sw_int_vg`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| dr_clk_en | input | 1 | Shift/capture clock enable for the shift stages |
| shift_sel | input | 1 | 1 = shift, 0 = capture when `dr_clk_en` is high |
| upd_en | input | 1 | Copies the shift stages into the update latches |
| mode_a | input | 1 | Global mode line a (test mode active) |
| mode_b | input | 1 | Global mode line b (internal test select) |
| mode_c | input | 1 | Global mode line c (extended group select) |
| scan_in | input | 1 | Serial data into the D stage |
| cmp_in | input | 1 | Comparator digital result |
| scan_out | output | 1 | Serial data from the B2 stage |
| sw_pin_vh | output | 1 | Pin to high reference |
| sw_pin_vl | output | 1 | Pin to low reference |
| sw_pin_vg | output | 1 | Pin to ground reference |
| sw_bus1 | output | 1 | Pin to analog bus 1 |
| sw_bus2 | output | 1 | Pin to analog bus 2 |
| sw_int_bus1 | output | 1 | Core to analog bus 1, bypassing the core switch |
| sw_int_bus2 | output | 1 | Core to analog bus 2, bypassing the core switch |
| sw_int_vg | output | 1 | Core to ground reference |
| cmp_sel_vh | output | 1 | Comparator reference = high level |
| cmp_sel_vl | output | 1 | Comparator reference = low level |
| cmp_sel_vg | output | 1 | Comparator reference = ground level |
| cmp_sel_vth | output | 1 | Comparator reference = threshold level |
| sw_core | output | 1 | Core connected to pin |

## Verification
The decoder is swept over all sixteen published codes under all eight mode-line combinations. The sweep shows whether the reference code reaches the pin group, the compare group or neither, and whether the bus bits land in the normal or the internal group. The codes 00 and 10 matter most, because they separate the threshold default from the low-level select and from the internal ground switch. Serial patterns with distinct bits in each stage show whether the order along the chain is correct. A capture with both comparator values, followed by an update, shows that only the D stage takes the comparator result.

// File: rtl/xbc_pkg.sv
package xbc_pkg;

    localparam int unsigned N_STAGES = 4;
    localparam int unsigned IDX_D    = 0;
    localparam int unsigned IDX_C    = 1;
    localparam int unsigned IDX_B1   = 2;
    localparam int unsigned IDX_B2   = 3;
    localparam int unsigned N_SW     = 13;

    // Two-bit reference code, packed as {C, D}
    typedef enum logic [1:0] {
        REF_NONE = 2'b00,
        REF_GND  = 2'b01,
        REF_LOW  = 2'b10,
        REF_HIGH = 2'b11
    } ref_code_e;

    typedef struct packed {
        logic b2;
        logic b1;
        logic c;
        logic d;
    } upd_word_t;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } mode_t;

    typedef struct packed {
        logic pin_vh;
        logic pin_vl;
        logic pin_vg;
        logic bus1;
        logic bus2;
        logic int_bus1;
        logic int_bus2;
        logic int_vg;
        logic sel_vh;
        logic sel_vl;
        logic sel_vg;
        logic sel_vth;
        logic core;
    } sw_vec_t;

    function automatic upd_word_t to_word(input logic [N_STAGES-1:0] q);
        upd_word_t w;
        w.d  = q[IDX_D];
        w.c  = q[IDX_C];
        w.b1 = q[IDX_B1];
        w.b2 = q[IDX_B2];
        return w;
    endfunction

    function automatic ref_code_e ref_of(input upd_word_t w);
        return ref_code_e'({w.c, w.d});
    endfunction

    // Pin reference enables: only in plain test mode with line c low
    function automatic logic pin_mode(input mode_t m);
        return m.a & ~m.b & ~m.c;
    endfunction

    // Compare-level mode: reference code steers the comparator input
    function automatic logic cmp_mode(input mode_t m);
        return m.a & ~m.b & m.c;
    endfunction

endpackage

// File: rtl/xbc_scan_stage.sv
module xbc_scan_stage #(
    parameter bit HAS_CAPTURE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic dr_clk_en,
    input  logic shift_sel,
    input  logic upd_en,
    input  logic ser_in,
    input  logic cap_in,
    output logic shift_q,
    output logic upd_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= 1'b0;
        end else if (dr_clk_en) begin
            if (shift_sel) begin
                shift_q <= ser_in;
            end else if (HAS_CAPTURE) begin
                shift_q <= cap_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_q <= 1'b0;
        end else if (upd_en) begin
            upd_q <= shift_q;
        end
    end

endmodule

// File: rtl/xbc_chain.sv
module xbc_chain
    import xbc_pkg::*;
#(
    parameter int unsigned STAGES  = N_STAGES,
    parameter int unsigned CAP_IDX = IDX_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dr_clk_en,
    input  logic              shift_sel,
    input  logic              upd_en,
    input  logic              scan_in,
    input  logic              cmp_in,
    output logic [STAGES-1:0] shift_q,
    output logic [STAGES-1:0] upd_q,
    output logic              scan_out
);

    logic [STAGES:0] link;

    assign link[0] = scan_in;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        xbc_scan_stage #(
            .HAS_CAPTURE(i == CAP_IDX)
        ) u_stage (
            .clk       (clk),
            .rst       (rst),
            .dr_clk_en (dr_clk_en),
            .shift_sel (shift_sel),
            .upd_en    (upd_en),
            .ser_in    (link[i]),
            .cap_in    (cmp_in),
            .shift_q   (shift_q[i]),
            .upd_q     (upd_q[i])
        );
        assign link[i+1] = shift_q[i];
    end

    assign scan_out = link[STAGES];

endmodule

// File: rtl/xbc_decode.sv
module xbc_decode
    import xbc_pkg::*;
(
    input  upd_word_t word,
    input  mode_t     mode,
    output sw_vec_t   sw
);

    ref_code_e code;
    logic      pin_on;
    logic      cmp_on;
    logic      int_test;

    assign code     = ref_of(word);
    assign pin_on   = pin_mode(mode);
    assign cmp_on   = cmp_mode(mode);
    assign int_test = mode.a & mode.b & mode.c;

    always_comb begin
        sw = '0;

        sw.pin_vh = pin_on & (code == REF_HIGH);
        sw.pin_vl = pin_on & (code == REF_LOW);
        sw.pin_vg = pin_on & (code == REF_GND);

        sw.bus1     = word.b1 & mode.a & ~mode.c;
        sw.bus2     = word.b2 & mode.a & ~mode.c;
        sw.int_bus1 = word.b1 & mode.a & mode.c;
        sw.int_bus2 = word.b2 & mode.a & mode.c;
        sw.int_vg   = (code == REF_LOW) & mode.a & mode.c;

        sw.sel_vh  = 1'b0;
        sw.sel_vl  = 1'b0;
        sw.sel_vg  = 1'b0;
        sw.sel_vth = 1'b1;
        if (cmp_on) begin
            unique case (code)
                REF_HIGH: begin sw.sel_vh = 1'b1; sw.sel_vth = 1'b0; end
                REF_LOW:  begin sw.sel_vl = 1'b1; sw.sel_vth = 1'b0; end
                REF_GND:  begin sw.sel_vg = 1'b1; sw.sel_vth = 1'b0; end
                default:  sw.sel_vth = 1'b1;
            endcase
        end

        sw.core = ~int_test;
    end

endmodule

// File: rtl/xbc_cell_ctl.sv
module xbc_cell_ctl
    import xbc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dr_clk_en,
    input  logic shift_sel,
    input  logic upd_en,
    input  logic mode_a,
    input  logic mode_b,
    input  logic mode_c,
    input  logic scan_in,
    input  logic cmp_in,
    output logic scan_out,
    output logic sw_pin_vh,
    output logic sw_pin_vl,
    output logic sw_pin_vg,
    output logic sw_bus1,
    output logic sw_bus2,
    output logic sw_int_bus1,
    output logic sw_int_bus2,
    output logic sw_int_vg,
    output logic cmp_sel_vh,
    output logic cmp_sel_vl,
    output logic cmp_sel_vg,
    output logic cmp_sel_vth,
    output logic sw_core
);

    logic [N_STAGES-1:0] stage_q;
    logic [N_STAGES-1:0] latch_q;
    upd_word_t           word;
    mode_t               mode;
    sw_vec_t             sw;

    xbc_chain #(
        .STAGES  (N_STAGES),
        .CAP_IDX (IDX_D)
    ) u_chain (
        .clk       (clk),
        .rst       (rst),
        .dr_clk_en (dr_clk_en),
        .shift_sel (shift_sel),
        .upd_en    (upd_en),
        .scan_in   (scan_in),
        .cmp_in    (cmp_in),
        .shift_q   (stage_q),
        .upd_q     (latch_q),
        .scan_out  (scan_out)
    );

    assign word = to_word(latch_q);
    assign mode = '{a: mode_a, b: mode_b, c: mode_c};

    xbc_decode u_dec (
        .word (word),
        .mode (mode),
        .sw   (sw)
    );

    assign sw_pin_vh   = sw.pin_vh;
    assign sw_pin_vl   = sw.pin_vl;
    assign sw_pin_vg   = sw.pin_vg;
    assign sw_bus1     = sw.bus1;
    assign sw_bus2     = sw.bus2;
    assign sw_int_bus1 = sw.int_bus1;
    assign sw_int_bus2 = sw.int_bus2;
    assign sw_int_vg   = sw.int_vg;
    assign cmp_sel_vh  = sw.sel_vh;
    assign cmp_sel_vl  = sw.sel_vl;
    assign cmp_sel_vg  = sw.sel_vg;
    assign cmp_sel_vth = sw.sel_vth;
    assign sw_core     = sw.core;

endmodule

// File: rtl/xbc_cell_chk.sv
module xbc_cell_chk (
    input logic       clk,
    input logic       rst,
    input logic       dr_clk_en,
    input logic       shift_sel,
    input logic       upd_en,
    input logic       mode_a,
    input logic       mode_b,
    input logic       mode_c,
    input logic       scan_in,
    input logic       scan_out,
    input logic [3:0] stage_q,
    input logic [3:0] cmp_sel,
    input logic [4:0] bus_grp,
    input logic [2:0] pin_grp,
    input logic       sw_core
);

    // R1
    shift_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (dr_clk_en && shift_sel) |=> (stage_q[0] == $past(scan_in)));

    // R1
    shift_tail_chk: assert property (@(posedge clk) disable iff (rst)
        (dr_clk_en && shift_sel) |=> (scan_out == $past(stage_q[2])));

    // R3
    capture_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (dr_clk_en && !shift_sel) |=> $stable(stage_q[3:1]));

    // R2
    hold_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        (!upd_en && !$past(rst) && $stable({mode_a, mode_b, mode_c}))
        |=> ($stable({cmp_sel, bus_grp, pin_grp}) || !$stable({mode_a, mode_b, mode_c})));

    // R9
    cmp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(cmp_sel) == 1);

    // R9
    vth_default_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_c |-> cmp_sel[0]);

    // R8
    pin_open_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_a && !mode_b && mode_c) |-> (pin_grp == 3'b000));

    // R11
    group_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !((bus_grp[4] || bus_grp[3]) && (bus_grp[2] || bus_grp[1] || bus_grp[0])));

    // R10
    core_open_chk: assert property (@(posedge clk) disable iff (rst)
        !sw_core |-> (mode_a && mode_b && mode_c));

endmodule

bind xbc_cell_ctl xbc_cell_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .dr_clk_en (dr_clk_en),
    .shift_sel (shift_sel),
    .upd_en    (upd_en),
    .mode_a    (mode_a),
    .mode_b    (mode_b),
    .mode_c    (mode_c),
    .scan_in   (scan_in),
    .scan_out  (scan_out),
    .stage_q   (stage_q),
    .cmp_sel   ({cmp_sel_vh, cmp_sel_vl, cmp_sel_vg, cmp_sel_vth}),
    .bus_grp   ({sw_bus1, sw_bus2, sw_int_bus1, sw_int_bus2, sw_int_vg}),
    .pin_grp   ({sw_pin_vh, sw_pin_vl, sw_pin_vg}),
    .sw_core   (sw_core)
);

// File: tb/sim_xbc_cell_ctl.sv
module sim_xbc_cell_ctl;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst, dr_clk_en, shift_sel, upd_en;
    logic mode_a, mode_b, mode_c, scan_in, cmp_in;
    logic scan_out;
    logic sw_pin_vh, sw_pin_vl, sw_pin_vg, sw_bus1, sw_bus2;
    logic sw_int_bus1, sw_int_bus2, sw_int_vg;
    logic cmp_sel_vh, cmp_sel_vl, cmp_sel_vg, cmp_sel_vth, sw_core;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    xbc_cell_ctl u0 (
        .clk(clk), .rst(rst), .dr_clk_en(dr_clk_en), .shift_sel(shift_sel),
        .upd_en(upd_en), .mode_a(mode_a), .mode_b(mode_b), .mode_c(mode_c),
        .scan_in(scan_in), .cmp_in(cmp_in), .scan_out(scan_out),
        .sw_pin_vh(sw_pin_vh), .sw_pin_vl(sw_pin_vl), .sw_pin_vg(sw_pin_vg),
        .sw_bus1(sw_bus1), .sw_bus2(sw_bus2), .sw_int_bus1(sw_int_bus1),
        .sw_int_bus2(sw_int_bus2), .sw_int_vg(sw_int_vg),
        .cmp_sel_vh(cmp_sel_vh), .cmp_sel_vl(cmp_sel_vl), .cmp_sel_vg(cmp_sel_vg),
        .cmp_sel_vth(cmp_sel_vth), .sw_core(sw_core)
    );

    function automatic logic [12:0] outs();
        return {sw_pin_vh, sw_pin_vl, sw_pin_vg, sw_bus1, sw_bus2,
                sw_int_bus1, sw_int_bus2, sw_int_vg,
                cmp_sel_vh, cmp_sel_vl, cmp_sel_vg, cmp_sel_vth, sw_core};
    endfunction

    // Expected switch vector from the requirements
    function automatic logic [12:0] model(input logic d, c, b1, b2, ma, mb, mc);
        logic hi, lo, gd, pin, cm;
        hi  = c & d;
        lo  = c & !d;
        gd  = !c & d;
        pin = ma & !mb & !mc;
        cm  = ma & !mb & mc;
        return {hi & pin, lo & pin, gd & pin,
                b1 & ma & !mc, b2 & ma & !mc,
                b1 & ma & mc, b2 & ma & mc, lo & ma & mc,
                hi & cm, lo & cm, gd & cm, !(cm & (c | d)),
                !(ma & mb & mc)};
    endfunction

    task automatic check_vec(input string req, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        dr_clk_en = 1'b1; shift_sel = 1'b1; scan_in = b;
        step();
        dr_clk_en = 1'b0; shift_sel = 1'b0;
    endtask

    task automatic pulse_update();
        upd_en = 1'b1;
        step();
        upd_en = 1'b0;
        #1;
    endtask

    task automatic load(input logic d, c, b1, b2);
        shift_bit(b2);
        shift_bit(b1);
        shift_bit(c);
        shift_bit(d);
        pulse_update();
    endtask

    task automatic set_mode(input logic ma, mb, mc);
        mode_a = ma; mode_b = mb; mode_c = mc;
        #1;
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; dr_clk_en = 1'b0; shift_sel = 1'b0; upd_en = 1'b0;
        scan_in = 1'b0; cmp_in = 1'b0;
        mode_a = 1'b1; mode_b = 1'b0; mode_c = 1'b0;
        @(negedge clk);
        step();
        #1;
        // R4 reset state
        check_vec("R4 reset outputs", outs(), model(0, 0, 0, 0, 1, 0, 0));
        check_bit("R4 reset scan_out", scan_out, 1'b0);
        rst = 1'b0;

        // R1 shift order: b2=1, b1=0, c=1, d=1
        shift_bit(1'b1);
        check_bit("R1 scan_out after 1 shift", scan_out, 1'b0);
        shift_bit(1'b0);
        shift_bit(1'b1);
        shift_bit(1'b1);
        #1;
        check_bit("R1 first bit reaches scan_out", scan_out, 1'b1);
        // R2 outputs still at reset values before update
        check_vec("R2 no update yet", outs(), model(0, 0, 0, 0, 1, 0, 0));
        pulse_update();
        check_vec("R5 loaded high code", outs(), model(1, 1, 0, 1, 1, 0, 0));

        // R1 shift out the rest: expect b1, c, d
        shift_bit(1'b0); #1;
        check_bit("R1 scan_out b1", scan_out, 1'b0);
        shift_bit(1'b0); #1;
        check_bit("R1 scan_out c", scan_out, 1'b1);
        shift_bit(1'b0); #1;
        check_bit("R1 scan_out d", scan_out, 1'b1);
        // R2 shifting left latches alone
        check_vec("R2 outputs held during shift", outs(), model(1, 1, 0, 1, 1, 0, 0));

        // R3 capture: load d=0 c=1 b1=1 b2=0, then capture cmp=1
        load(1'b0, 1'b1, 1'b1, 1'b0);
        check_vec("R5 loaded low code", outs(), model(0, 1, 1, 0, 1, 0, 0));
        cmp_in = 1'b1;
        dr_clk_en = 1'b1; shift_sel = 1'b0;
        step();
        dr_clk_en = 1'b0;
        #1;
        check_bit("R3 capture keeps B2", scan_out, 1'b0);
        check_vec("R2 outputs held after capture", outs(), model(0, 1, 1, 0, 1, 0, 0));
        pulse_update();
        check_vec("R3 capture into D", outs(), model(1, 1, 1, 0, 1, 0, 0));
        cmp_in = 1'b0;
        dr_clk_en = 1'b1; shift_sel = 1'b0;
        step();
        dr_clk_en = 1'b0;
        pulse_update();
        check_vec("R3 capture zero into D", outs(), model(0, 1, 1, 0, 1, 0, 0));

        // Full sweep of codes and modes: R5 R6 R7 R8 R9 R10 R11
        for (int code = 0; code < 16; code++) begin
            load(code[0], code[1], code[2], code[3]);
            for (int m = 0; m < 8; m++) begin
                set_mode(m[2], m[1], m[0]);
                check_vec("R5/R6/R7/R8/R10 sweep", outs(),
                          model(code[0], code[1], code[2], code[3], m[2], m[1], m[0]));
                check_bit("R9 compare select one-hot",
                          ($countones({cmp_sel_vh, cmp_sel_vl, cmp_sel_vg, cmp_sel_vth}) == 1), 1'b1);
                check_bit("R11 groups exclusive",
                          ((sw_bus1 | sw_bus2) & (sw_int_bus1 | sw_int_bus2 | sw_int_vg)), 1'b0);
            end
        end

        // R4 reset mid-operation clears latches
        load(1'b1, 1'b1, 1'b1, 1'b1);
        set_mode(1, 0, 1);
        check_vec("R8 high compare level", outs(), model(1, 1, 1, 1, 1, 0, 1));
        rst = 1'b1;
        step();
        rst = 1'b0;
        #1;
        check_vec("R4 reset clears latches", outs(), model(0, 0, 0, 0, 1, 0, 1));
        check_bit("R4 reset clears chain", scan_out, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule